// File: doc/BRIEF.md
# Translation Table Update Engine

This block maintains a small set of address translation tables on behalf of a processor. Each table is named by a 32-bit logical bus number and is described by a bus offset, a page shift and an entry count. These are supplied on configuration inputs. An entry count of zero leaves a table with no usable entries. A command port accepts four operations: store one entry, fetch one entry, fill a run of pages with one value, and write a run of pages whose values come from a list in memory. The list is reached through a simple read-request port.

Each command runs to completion before the next is taken. It ends with a one-cycle `done` pulse that carries a status. Every entry that is actually stored also produces a one-cycle change notification. The notification lets a downstream translation cache or shadow copy follow the table without reading it back.

A batch command that meets a bad page stops there and reports the error. Pages stored before that point are kept.

Top module: `xlt_update_engine`

## Requirements
- R1: A command whose table identifier has any bit of [63:32] set, or whose low 32 bits match no configured table, ends with status 1 (parameter error) and stores nothing. When several tables match, the lowest-numbered one is used.
- R2: The IO address of every command is rounded down to a multiple of 2^shift of the selected table before any index is formed.
- R3: The entry index is (aligned IO address − bus offset) >> shift, computed modulo 2^64. An index at or above the table's entry count gives status 1 and leaves the table unchanged.
- R4: The store-one command (op 0) writes `cmd_arg` to the indexed entry. The fetch-one command (op 1) returns the stored 64-bit entry unchanged on `rd_data`, in the `done` cycle, with status 0.
- R5: The fill command (op 2) gives status 1 without storing anything when `cmd_count` exceeds the table's entry count. Otherwise it stores `cmd_arg` into `cmd_count` consecutive pages, starting at the aligned IO address.
- R6: The list command (op 3) gives status 1 without any memory request when `cmd_count` > 512 or when `cmd_arg[11:0]` is nonzero. Otherwise, step k reads the 64-bit word at `cmd_arg + 8k` and stores it as step k's entry. In `mem_rdata`, bits [7:0] hold the byte at the lowest address, and that byte is the most significant byte of the entry.
- R7: Fill and list advance the IO address by one page per step. They stop at the first step whose index is out of range and return status 1. Entries stored by earlier steps are kept.
- R8: Every stored entry raises `ntf_valid` for one cycle with these fields: `ntf_iova` = (aligned address − offset) & pmask; `ntf_xlat` = entry & pmask; `ntf_mask` = ~pmask; `ntf_perm` = entry[1:0]. Here pmask = ~(2^shift − 1). In `ntf_perm`, bit 0 means read allowed and bit 1 means write allowed.
- R9: A fill or list command with `cmd_count` = 0 ends with status 1, stores nothing and issues no memory request.
- R10: `cmd_ready` is high only while the engine is idle. After a command is accepted it falls until `done`. `done` is a single-cycle pulse, and `status` is 0 for success and 1 for parameter error.
- R11: Reset clears every entry of every table to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_id | input | NTAB*32 | Bus number of each table, table t at [t*32 +: 32] |
| cfg_base | input | NTAB*64 | Bus offset of each table |
| cfg_shift | input | NTAB*6 | Page shift of each table |
| cfg_len | input | NTAB*CW | Entry count of each table (at most MAXE) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 2 | 0 store one, 1 fetch one, 2 fill, 3 list |
| cmd_id | input | 64 | Table identifier |
| cmd_ioba | input | 64 | IO bus address |
| cmd_arg | input | 64 | Entry value (store, fill) or list address (list) |
| cmd_count | input | 16 | Page count for fill and list |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 success, 1 parameter error; valid with done |
| rd_data | output | 64 | Fetched entry; valid with done |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Read data, lowest-address byte in [7:0] |
| ntf_valid | output | 1 | Entry-change notification |
| ntf_iova | output | 64 | Offset-relative page address |
| ntf_xlat | output | 64 | Masked translated address |
| ntf_mask | output | 64 | Inverted page mask |
| ntf_perm | output | 2 | Permission: bit 0 read, bit 1 write |

## Verification
The embedded properties watch, on every cycle, the handshake shape: `done` is a lone pulse, and `cmd_ready` drops after an accept. They also check that list fetches are 8-byte aligned and belong to a non-empty list command, and that the notification addresses carry no bits below the page mask. Table selection, alignment, bounds, batch early stop, byte order and the contents kept in the tables can only be shown by the bench scenarios. These compare status, fetched entries and the count and content of notifications against a reference model of the requirements.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;

    typedef enum logic [1:0] {
        OP_PUT  = 2'd0,
        OP_GET  = 2'd1,
        OP_FILL = 2'd2,
        OP_LIST = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_STEP, S_FETCH, S_WAIT
    } state_e;

    localparam logic ST_OK   = 1'b0;
    localparam logic ST_PERR = 1'b1;

    // lowest-address byte arrives in [7:0] and is the most significant
    function automatic logic [63:0] swap_bytes(input logic [63:0] raw);
        logic [63:0] res;
        for (int b = 0; b < 8; b++) res[b*8 +: 8] = raw[(7-b)*8 +: 8];
        return res;
    endfunction

endpackage

// File: rtl/xlt_table_sel.sv
`timescale 1ns/1ps
module xlt_table_sel #(
    parameter int NTAB = 2,
    parameter int CW   = 5,
    localparam int TW  = (NTAB > 1) ? $clog2(NTAB) : 1
) (
    input  logic [NTAB*32-1:0] cfg_id,
    input  logic [NTAB*64-1:0] cfg_base,
    input  logic [NTAB*6-1:0]  cfg_shift,
    input  logic [NTAB*CW-1:0] cfg_len,
    input  logic [63:0]        id,
    output logic               hit,
    output logic [TW-1:0]      sel,
    output logic [63:0]        base,
    output logic [5:0]         shift,
    output logic [CW-1:0]      len
);
    logic [NTAB-1:0] match;

    for (genvar t = 0; t < NTAB; t++) begin : g_match
        assign match[t] = (cfg_id[t*32 +: 32] == id[31:0]);
    end

    always_comb begin
        sel = '0;
        for (int t = NTAB - 1; t >= 0; t--) begin
            if (match[t]) sel = TW'(t);
        end
    end

    assign hit   = (|match) && (id[63:32] == 32'd0);
    assign base  = cfg_base[sel*64 +: 64];
    assign shift = cfg_shift[sel*6 +: 6];
    assign len   = cfg_len[sel*CW +: CW];
endmodule

// File: rtl/xlt_page_calc.sv
`timescale 1ns/1ps
module xlt_page_calc #(
    parameter int CW = 5,
    parameter int IW = 4
) (
    input  logic [63:0]   addr,
    input  logic [63:0]   base,
    input  logic [5:0]    shift,
    input  logic [CW-1:0] len,
    input  logic [63:0]   value,
    output logic          in_range,
    output logic [IW-1:0] idx,
    output logic [63:0]   next_addr,
    output logic [63:0]   iova,
    output logic [63:0]   xlat,
    output logic [63:0]   mask
);
    logic [63:0] psize, pmask, al, diff, idx_full;

    assign psize     = 64'd1 << shift;
    assign pmask     = ~(psize - 64'd1);
    assign al        = addr & pmask;
    assign diff      = al - base;
    assign idx_full  = diff >> shift;
    assign in_range  = idx_full < 64'(len);
    assign idx       = idx_full[IW-1:0];
    assign next_addr = al + psize;
    assign iova      = diff & pmask;
    assign xlat      = value & pmask;
    assign mask      = ~pmask;
endmodule

// File: rtl/xlt_entry_store.sv
`timescale 1ns/1ps
module xlt_entry_store #(
    parameter int NTAB = 2,
    parameter int MAXE = 16,
    localparam int TW  = (NTAB > 1) ? $clog2(NTAB) : 1,
    localparam int IW  = (MAXE > 1) ? $clog2(MAXE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] tab,
    input  logic [IW-1:0] idx,
    input  logic [63:0]   wr_data,
    output logic [63:0]   rd_data
);
    logic [63:0] ent_q [NTAB][MAXE];
    logic [63:0] ent_d [NTAB][MAXE];

    always_comb begin
        ent_d = ent_q;
        if (wr_en) ent_d[tab][idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTAB; t++)
                for (int e = 0; e < MAXE; e++)
                    ent_q[t][e] <= 64'd0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_data = ent_q[tab][idx];
endmodule

// File: rtl/xlt_update_engine.sv
`timescale 1ns/1ps
module xlt_update_engine
    import xlt_pkg::*;
#(
    parameter int NTAB       = 2,
    parameter int MAXE       = 16,
    parameter int CNT_W      = 16,
    parameter int MAX_BATCH  = 512,
    parameter int LIST_ALIGN = 12,
    localparam int CW = $clog2(MAXE + 1),
    localparam int TW = (NTAB > 1) ? $clog2(NTAB) : 1,
    localparam int IW = (MAXE > 1) ? $clog2(MAXE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTAB*32-1:0] cfg_id,
    input  logic [NTAB*64-1:0] cfg_base,
    input  logic [NTAB*6-1:0]  cfg_shift,
    input  logic [NTAB*CW-1:0] cfg_len,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [63:0]        cmd_id,
    input  logic [63:0]        cmd_ioba,
    input  logic [63:0]        cmd_arg,
    input  logic [CNT_W-1:0]   cmd_count,
    output logic               done,
    output logic               status,
    output logic [63:0]        rd_data,
    output logic               mem_req,
    output logic [63:0]        mem_addr,
    input  logic               mem_rvalid,
    input  logic [63:0]        mem_rdata,
    output logic               ntf_valid,
    output logic [63:0]        ntf_iova,
    output logic [63:0]        ntf_xlat,
    output logic [63:0]        ntf_mask,
    output logic [1:0]         ntf_perm
);
    typedef struct packed {
        state_e           st;
        op_e              op;
        logic [63:0]      id;
        logic [63:0]      ioba;
        logic [63:0]      arg;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             status;
        logic [63:0]      rdat;
        logic             nv;
        logic [63:0]      niova;
        logic [63:0]      nxlat;
        logic [63:0]      nmask;
        logic [1:0]       nperm;
        logic             mreq;
        logic [63:0]      maddr;
    } regs_t;

    regs_t r_d, r_q;

    logic          hit, pg_ok, we, page_go;
    logic [TW-1:0] sel;
    logic [63:0]   sel_base, wval, next_addr, iova, xlat, pmask_inv, entry_rd;
    logic [5:0]    sel_shift;
    logic [CW-1:0] sel_len;
    logic [IW-1:0] idx;

    xlt_table_sel #(.NTAB(NTAB), .CW(CW)) u_sel (
        .cfg_id(cfg_id), .cfg_base(cfg_base), .cfg_shift(cfg_shift),
        .cfg_len(cfg_len), .id(r_q.id), .hit(hit), .sel(sel),
        .base(sel_base), .shift(sel_shift), .len(sel_len)
    );

    assign wval = (r_q.op == OP_LIST) ? swap_bytes(mem_rdata) : r_q.arg;

    xlt_page_calc #(.CW(CW), .IW(IW)) u_calc (
        .addr(r_q.ioba), .base(sel_base), .shift(sel_shift), .len(sel_len),
        .value(wval), .in_range(pg_ok), .idx(idx), .next_addr(next_addr),
        .iova(iova), .xlat(xlat), .mask(pmask_inv)
    );

    xlt_entry_store #(.NTAB(NTAB), .MAXE(MAXE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .tab(sel), .idx(idx),
        .wr_data(wval), .rd_data(entry_rd)
    );

    assign page_go = (r_q.st == S_STEP) || (r_q.st == S_WAIT && mem_rvalid);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.nv   = 1'b0;
        r_d.mreq = 1'b0;
        we       = 1'b0;
        case (r_q.st)
            S_IDLE: if (cmd_valid) begin
                r_d.st    = S_CHECK;
                r_d.op    = op_e'(cmd_op);
                r_d.id    = cmd_id;
                r_d.ioba  = cmd_ioba;
                r_d.arg   = cmd_arg;
                r_d.count = cmd_count;
                r_d.cnt   = '0;
            end
            S_CHECK: begin
                r_d.st     = S_IDLE;
                r_d.done   = 1'b1;
                r_d.status = ST_PERR;
                if (hit) begin
                    case (r_q.op)
                        OP_GET: if (pg_ok) begin
                            r_d.rdat   = entry_rd;
                            r_d.status = ST_OK;
                        end
                        OP_PUT: begin
                            r_d.count = CNT_W'(1);
                            r_d.st    = S_STEP;
                            r_d.done  = 1'b0;
                        end
                        OP_FILL: if (r_q.count != '0 &&
                                     32'(r_q.count) <= 32'(sel_len)) begin
                            r_d.st   = S_STEP;
                            r_d.done = 1'b0;
                        end
                        default: if (r_q.count != '0 &&
                                     r_q.count <= CNT_W'(MAX_BATCH) &&
                                     r_q.arg[LIST_ALIGN-1:0] == '0) begin
                            r_d.st   = S_FETCH;
                            r_d.done = 1'b0;
                        end
                    endcase
                end
            end
            S_FETCH: begin
                r_d.mreq  = 1'b1;
                r_d.maddr = r_q.arg + (64'(r_q.cnt) << 3);
                r_d.st    = S_WAIT;
            end
            default: ;
        endcase

        if (page_go) begin
            if (!pg_ok) begin
                r_d.st     = S_IDLE;
                r_d.done   = 1'b1;
                r_d.status = ST_PERR;
            end else begin
                we        = 1'b1;
                r_d.nv    = 1'b1;
                r_d.niova = iova;
                r_d.nxlat = xlat;
                r_d.nmask = pmask_inv;
                r_d.nperm = wval[1:0];
                if (r_q.cnt + CNT_W'(1) == r_q.count) begin
                    r_d.st     = S_IDLE;
                    r_d.done   = 1'b1;
                    r_d.status = ST_OK;
                end else begin
                    r_d.cnt  = r_q.cnt + CNT_W'(1);
                    r_d.ioba = next_addr;
                    r_d.st   = (r_q.op == OP_LIST) ? S_FETCH : S_STEP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ready = (r_q.st == S_IDLE);
    assign done      = r_q.done;
    assign status    = r_q.status;
    assign rd_data   = r_q.rdat;
    assign mem_req   = r_q.mreq;
    assign mem_addr  = r_q.maddr;
    assign ntf_valid = r_q.nv;
    assign ntf_iova  = r_q.niova;
    assign ntf_xlat  = r_q.nxlat;
    assign ntf_mask  = r_q.nmask;
    assign ntf_perm  = r_q.nperm;

    // R10: completion is a lone pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: no second command is taken while one is in flight
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R6: list fetches are word aligned and belong to a list command
    a_r6_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'd0 && r_q.op == OP_LIST));
    // R9: no fetch for an empty list
    a_r9_no_empty_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (r_q.count != '0));
    // R8: notified addresses carry no sub-page bits
    a_r8_page_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> ((ntf_xlat & ntf_mask) == 64'd0 &&
                       (ntf_iova & ntf_mask) == 64'd0));
endmodule

// File: tb/xlt_update_engine_test.sv
`timescale 1ns/1ps
module xlt_update_engine_test;
    localparam int NT = 2;
    localparam int ME = 16;
    localparam int CW = $clog2(ME + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [63:0] t_id [NT], t_base [NT];
    logic [5:0]  t_sh [NT];
    int          t_len [NT];
    initial begin
        t_id[0] = 64'h0000_0001; t_base[0] = 64'd0;              t_sh[0] = 6'd12; t_len[0] = 16;
        t_id[1] = 64'h8000_0002; t_base[1] = 64'h1_0000_0000;    t_sh[1] = 6'd16; t_len[1] = 8;
    end

    logic [NT*32-1:0] cfg_id;
    logic [NT*64-1:0] cfg_base;
    logic [NT*6-1:0]  cfg_shift;
    logic [NT*CW-1:0] cfg_len;
    assign cfg_id    = {t_id[1][31:0], t_id[0][31:0]};
    assign cfg_base  = {t_base[1], t_base[0]};
    assign cfg_shift = {t_sh[1], t_sh[0]};
    assign cfg_len   = {CW'(t_len[1]), CW'(t_len[0])};

    logic        cmd_valid = 1'b0, cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [63:0] cmd_id = '0, cmd_ioba = '0, cmd_arg = '0;
    logic [15:0] cmd_count = '0;
    logic        done, status, mem_req, ntf_valid;
    logic [63:0] rd_data, mem_addr, ntf_iova, ntf_xlat, ntf_mask;
    logic [1:0]  ntf_perm;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    xlt_update_engine #(.NTAB(NT), .MAXE(ME)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .cfg_base(cfg_base),
        .cfg_shift(cfg_shift), .cfg_len(cfg_len), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .cmd_ioba(cmd_ioba), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
        .done(done), .status(status), .rd_data(rd_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
        .ntf_mask(ntf_mask), .ntf_perm(ntf_perm)
    );

    // memory model: raw word as it sits in memory, lowest byte in [7:0]
    function automatic logic [63:0] memword(input logic [63:0] a);
        return {a[31:0] ^ 32'h1234_5678, ~a[31:0] ^ {a[15:0], a[15:0]}};
    endfunction
    function automatic logic [63:0] be64(input logic [63:0] raw);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[63-b*8 -: 8] = raw[b*8 +: 8];
        return r;
    endfunction

    logic        pend = 1'b0;
    logic [63:0] paddr = '0;
    int          lat = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend <= 1'b1; paddr <= mem_addr; lat <= 2;
        end else if (pend) begin
            if (lat == 0) begin
                mem_rvalid <= 1'b1; mem_rdata <= memword(paddr); pend <= 1'b0;
            end else lat <= lat - 1;
        end
    end

    int n_checks = 0, n_fail = 0;
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // reference model of the tables
    logic [63:0] mdl [NT][ME];
    logic        e_st;
    logic [63:0] e_rd, e_li, e_lx, e_lm;
    logic [1:0]  e_lp;
    int          e_nn;

    function automatic int lookup(input logic [63:0] id);
        if (id[63:32] != 0) return -1;
        for (int t = 0; t < NT; t++) if (t_id[t][31:0] == id[31:0]) return t;
        return -1;
    endfunction

    function automatic bit put_one(input int t, input logic [63:0] a, input logic [63:0] v);
        logic [63:0] pm, rel, ix;
        pm  = ~((64'd1 << t_sh[t]) - 64'd1);
        rel = (a & pm) - t_base[t];
        ix  = rel >> t_sh[t];
        if (ix >= 64'(t_len[t])) return 1'b0;
        mdl[t][ix[3:0]] = v;
        e_nn++; e_li = rel & pm; e_lx = v & pm; e_lm = ~pm; e_lp = v[1:0];
        return 1'b1;
    endfunction

    task automatic model(input logic [1:0] op, input logic [63:0] id, ioba, arg, input int n);
        int t;
        logic [63:0] pm, a, ix, ps;
        e_st = 1'b1; e_rd = '0; e_nn = 0;
        t = lookup(id);
        if (t < 0) return;
        pm = ~((64'd1 << t_sh[t]) - 64'd1);
        ps = 64'd1 << t_sh[t];
        a  = ioba & pm;
        case (op)
            2'd1: begin
                ix = (a - t_base[t]) >> t_sh[t];
                if (ix < 64'(t_len[t])) begin e_st = 1'b0; e_rd = mdl[t][ix[3:0]]; end
            end
            2'd0: e_st = !put_one(t, a, arg);
            2'd2: if (n != 0 && n <= t_len[t]) begin
                e_st = 1'b0;
                for (int k = 0; k < n; k++) begin
                    if (!put_one(t, a, arg)) begin e_st = 1'b1; break; end
                    a = a + ps;
                end
            end
            default: if (n != 0 && n <= 512 && arg[11:0] == 0) begin
                e_st = 1'b0;
                for (int k = 0; k < n; k++) begin
                    if (!put_one(t, a, be64(memword(arg + 64'(k) * 8)))) begin e_st = 1'b1; break; end
                    a = a + ps;
                end
            end
        endcase
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [63:0] id, ioba, arg,
                           input int n, input string tag);
        int got;
        logic [63:0] gi, gx, gm;
        logic [1:0]  gp;
        model(op, id, ioba, arg, n);
        @(negedge clk);
        cmd_op = op; cmd_id = id; cmd_ioba = ioba; cmd_arg = arg;
        cmd_count = 16'(n); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R10 ready while busy", 64'(cmd_ready), 64'd0);
        got = 0; gi = '0; gx = '0; gm = '0; gp = '0;
        forever begin
            if (ntf_valid) begin got++; gi = ntf_iova; gx = ntf_xlat; gm = ntf_mask; gp = ntf_perm; end
            if (done) break;
            @(negedge clk);
        end
        check(status == e_st, {tag, " status"}, 64'(status), 64'(e_st));
        if (op == 2'd1 && e_st == 1'b0)
            check(rd_data == e_rd, {tag, " R4 read data"}, rd_data, e_rd);
        check(got == e_nn, {tag, " R8 notify count"}, 64'(got), 64'(e_nn));
        if (got > 0 && e_nn > 0) begin
            check(gi == e_li, {tag, " R8 iova"}, gi, e_li);
            check(gx == e_lx, {tag, " R8 xlat"}, gx, e_lx);
            check(gm == e_lm, {tag, " R8 mask"}, gm, e_lm);
            check(64'(gp) == 64'(e_lp), {tag, " R8 perm"}, 64'(gp), 64'(e_lp));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] id1, bad;
        int r, tsel, n;
        logic [1:0] op;
        logic [63:0] ioba, arg, id;
        for (int t = 0; t < NT; t++) for (int e = 0; e < ME; e++) mdl[t][e] = '0;
        void'($urandom(32'h5eed_1234));
        id1 = t_id[1];
        bad = t_id[0] | 64'h100_0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(cmd_ready == 1'b1, "R10 ready after reset", 64'(cmd_ready), 64'd1);

        // R11: entries are zero after reset
        run_cmd(2'd1, t_id[0], 64'h3000, 0, 0, "R11 reset t0");
        run_cmd(2'd1, id1, t_base[1] + 64'h3_0000, 0, 0, "R11 reset t1");
        // R2/R4: unaligned address lands on page 5
        run_cmd(2'd0, t_id[0], 64'h5123, 64'hDEAD_BEEF_0000_1ABF, 0, "R2 put unaligned");
        run_cmd(2'd1, t_id[0], 64'h5FFF, 0, 0, "R4 get back");
        // R1: upper identifier bits, unknown identifier
        run_cmd(2'd0, bad, 64'h5000, 64'h1111, 0, "R1 upper bits");
        run_cmd(2'd0, 64'h77, 64'h5000, 64'h2222, 0, "R1 no table");
        run_cmd(2'd1, t_id[0], 64'h5000, 0, 0, "R1 entry untouched");
        // R3: bounds
        run_cmd(2'd0, t_id[0], 64'h1_0000, 64'h3333, 0, "R3 index at count");
        run_cmd(2'd0, id1, t_base[1] - 64'h1_0000, 64'h3333, 0, "R3 below offset");
        run_cmd(2'd0, id1, t_base[1] + 64'h7_8001, 64'hABCD_0003, 0, "R3 last index");
        // R5 / R9
        run_cmd(2'd2, t_id[0], 64'h0, 64'h5555_0001, 17, "R5 fill too long");
        run_cmd(2'd2, t_id[0], 64'h0, 64'h5555_0001, 0, "R9 fill zero");
        run_cmd(2'd2, t_id[0], 64'h2000, 64'h6666_0002, 3, "R5 fill three");
        // R7: fill crossing the end keeps earlier pages
        run_cmd(2'd2, t_id[0], 64'hE000, 64'h7777_0003, 4, "R7 fill stops");
        run_cmd(2'd1, t_id[0], 64'hF000, 0, 0, "R7 kept page");
        // R6 / R9 list
        run_cmd(2'd3, id1, t_base[1], 64'h10_0000, 0, "R9 list zero");
        run_cmd(2'd3, id1, t_base[1], 64'h10_0000, 513, "R6 list too long");
        run_cmd(2'd3, id1, t_base[1], 64'h10_0008, 2, "R6 list unaligned");
        run_cmd(2'd3, id1, t_base[1] + 64'h1_0000, 64'h10_0000, 3, "R6 list three");
        run_cmd(2'd1, id1, t_base[1] + 64'h2_0000, 0, 0, "R6 byte order");
        run_cmd(2'd3, id1, t_base[1] + 64'h6_0000, 64'h20_0000, 4, "R7 list stops");
        run_cmd(2'd1, id1, t_base[1] + 64'h7_0000, 0, 0, "R7 list kept");

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            r = $urandom % 8;
            tsel = (r >= 3 && r <= 5) ? 1 : 0;
            id = (r <= 2) ? t_id[0] : (r <= 5) ? id1 : (r == 6) ? bad : 64'h77;
            op = 2'($urandom % 4);
            ioba = t_base[tsel] + (64'($urandom % 20) << t_sh[tsel]) + 64'($urandom % 4096);
            if ($urandom % 16 == 0) ioba = t_base[tsel] - 64'd1;
            r = $urandom % 10;
            n = (r == 0) ? 0 : (r == 9) ? (($urandom % 2) ? 17 : 600) : 1 + $urandom % 5;
            if (op == 2'd3)
                arg = 64'h10_0000 + 64'($urandom % 64) * 4096 + (($urandom % 8 == 0) ? 64'd8 : 64'd0);
            else
                arg = {$urandom, $urandom};
            run_cmd(op, id, ioba, arg, n,
                    (op == 2'd2) ? "R5 random fill" : (op == 2'd3) ? "R6 random list" :
                    (op == 2'd1) ? "R4 random get" : "R3 random put");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule